// File: doc/BRIEF.md
# Dock Attach Sequencer Registers

This block lets software connect or disconnect a removable audio codec dock through two byte-wide registers on a simple register bus. Software sets or clears an attach request bit in the control register. A small sequencer then drives two active-low pins, a dock enable and a dock reset, in a fixed order with a timed gap between them. Only when the pin sequence has finished does a separate mated flag in the status register change to match the request. Software therefore polls the mated flag to learn that a transfer is complete.

A capability flag in the status register says whether docking is permitted. It can be written once and then locks. It sits in the platform reset domain, so the controller reset leaves it alone. While the capability flag is clear, the attach request bit cannot be changed. The gap between the two pin edges is a parameter, `WAIT_CYCLES`, with a default of 16 clocks.

Top module: `dock_seq_regs`

## Requirements
- R1: After platform reset the control register reads 0x00, the status register reads 0x80, `dock_en_n` is 1 and `dock_rst_n` is 0.
- R2: Reads are combinational on `reg_addr`. The control register is at 0x4C: bit 0 is the attach request and bits 7:1 read 0. The status register is at 0x4D: bit 7 is the capability flag, bit 0 is the mated flag and bits 6:1 read 0. Every other offset reads 0x00.
- R3: A write of 1 to the attach bit is accepted when the bit is 0, the capability flag is 1 and no sequence is running. `dock_en_n` goes low on the write edge. `dock_rst_n` goes high `WAIT_CYCLES` clocks later. The mated flag goes to 1 one clock after that.
- R4: A write of 0 to the attach bit is accepted when the bit is 1, the capability flag is 1 and no sequence is running. `dock_rst_n` goes low on the write edge. `dock_en_n` goes high `WAIT_CYCLES` clocks later. The mated flag goes to 0 one clock after that.
- R5: While the capability flag is 0, writes to the attach bit leave it unchanged and start no sequence.
- R6: An attach write that repeats the current value, or that arrives while a sequence is running, leaves the attach bit unchanged and does not disturb the pins or the running sequence.
- R7: The first write to the status register loads the capability flag from write-data bit 7 and locks it. Later writes have no effect until the next platform reset. Writes never alter the mated flag.
- R8: The controller reset clears the attach bit and the mated flag, stops the sequencer, and drives `dock_en_n` to 1 and `dock_rst_n` to 0. It does not change the capability flag or its lock.
- R9: The platform reset restores everything, including setting the capability flag to 1 and clearing its lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_plat_n | input | 1 | Platform reset, asynchronous, active low; resets every register |
| rst_ctl_n | input | 1 | Controller reset, asynchronous, active low; spares the capability flag |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dock_en_n | output | 1 | Dock enable, active low |
| dock_rst_n | output | 1 | Dock reset, active low |

## Verification
The bench tracks every clock of both sequences. A design with an off-by-one gap, or with the two pin edges in the wrong order, moves a pin or the mated flag one cycle early or late, or briefly releases reset while the dock is still disabled. Writes arrive mid-sequence, as same-value repeats, with junk in the reserved bits, and while the capability flag is clear. A design that does not filter these would restart or abort a sequence, or would let the attach bit drift away from the mated flag. All 256 status write values are swept after fresh platform resets, each followed by an inverted second write. A lock that is missing, or a capability flag that the controller reset wipes, then reads back the wrong bit 7.

// File: rtl/dock_seq_pkg.sv
package dock_seq_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned ATTACH_BIT = 0;
    localparam int unsigned CAP_BIT    = 7;
    localparam int unsigned MATED_BIT  = 0;

    typedef enum logic [2:0] {
        SQ_IDLE          = 3'd0,
        SQ_DOCK_WAIT     = 3'd1,
        SQ_DOCK_SETTLE   = 3'd2,
        SQ_UNDOCK_WAIT   = 3'd3,
        SQ_UNDOCK_SETTLE = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic supported;
        logic locked;
    } cap_state_t;

    typedef struct packed {
        logic attach;
    } ctl_state_t;

endpackage

// File: rtl/dock_cap_reg.sv
module dock_cap_reg
    import dock_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_plat_n,
    input  logic cap_wr,
    input  logic cap_wbit,
    output logic supported
);

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cap_wr && !cap_q.locked) begin
            cap_d.supported = cap_wbit;
            cap_d.locked    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_plat_n) begin
        if (!rst_plat_n) begin
            cap_q <= '{supported: 1'b1, locked: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign supported = cap_q.supported;

endmodule

// File: rtl/dock_seq_fsm.sv
module dock_seq_fsm
    import dock_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_dock,
    input  logic start_undock,
    output logic dock_en_n,
    output logic dock_rst_n,
    output logic mated,
    output logic busy
);

    localparam int unsigned CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             en_n;
        logic             rst_n;
        logic             mated;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        state: SQ_IDLE,
        cnt:   '0,
        en_n:  1'b1,
        rst_n: 1'b0,
        mated: 1'b0
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (start_dock) begin
                    s_d.state = SQ_DOCK_WAIT;
                    s_d.en_n  = 1'b0;
                    s_d.cnt   = '0;
                end else if (start_undock) begin
                    s_d.state = SQ_UNDOCK_WAIT;
                    s_d.rst_n = 1'b0;
                    s_d.cnt   = '0;
                end
            end
            SQ_DOCK_WAIT: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.rst_n = 1'b1;
                    s_d.state = SQ_DOCK_SETTLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_DOCK_SETTLE: begin
                s_d.mated = 1'b1;
                s_d.state = SQ_IDLE;
            end
            SQ_UNDOCK_WAIT: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.en_n  = 1'b1;
                    s_d.state = SQ_UNDOCK_SETTLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_UNDOCK_SETTLE: begin
                s_d.mated = 1'b0;
                s_d.state = SQ_IDLE;
            end
            default: s_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign dock_en_n  = s_q.en_n;
    assign dock_rst_n = s_q.rst_n;
    assign mated      = s_q.mated;
    assign busy       = (s_q.state != SQ_IDLE);

endmodule

// File: rtl/dock_reg_file.sv
module dock_reg_file
    import dock_seq_pkg::*;
#(
    parameter logic [7:0] CTRL_OFS = 8'h4C,
    parameter logic [7:0] STAT_OFS = 8'h4D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             wr_attach_bit,
    input  logic             wr_cap_bit,
    input  logic             supported,
    input  logic             mated,
    input  logic             busy,
    output logic             attach,
    output logic             start_dock,
    output logic             start_undock,
    output logic             cap_wr,
    output logic             cap_wbit,
    output logic [REG_W-1:0] reg_rdata
);

    ctl_state_t ctl_d, ctl_q;
    logic       hit_ctrl;
    logic       accept;

    always_comb begin
        hit_ctrl     = reg_wr && (reg_addr == CTRL_OFS);
        accept       = hit_ctrl && supported && !busy && (wr_attach_bit != ctl_q.attach);
        start_dock   = accept && wr_attach_bit;
        start_undock = accept && !wr_attach_bit;
        ctl_d        = ctl_q;
        if (accept) begin
            ctl_d.attach = wr_attach_bit;
        end
        cap_wr   = reg_wr && (reg_addr == STAT_OFS);
        cap_wbit = wr_cap_bit;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[ATTACH_BIT] = ctl_q.attach;
        end else if (reg_addr == STAT_OFS) begin
            reg_rdata[CAP_BIT]   = supported;
            reg_rdata[MATED_BIT] = mated;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{attach: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign attach = ctl_q.attach;

endmodule

// File: rtl/dock_seq_regs.sv
module dock_seq_regs
    import dock_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 16,
    parameter logic [7:0]  CTRL_OFS    = 8'h4C,
    parameter logic [7:0]  STAT_OFS    = 8'h4D
) (
    input  logic       clk,
    input  logic       rst_plat_n,
    input  logic       rst_ctl_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       dock_en_n,
    output logic       dock_rst_n
);

    // Controller-domain registers also clear on the platform reset.
    logic ctl_rst_n;
    logic supported;
    logic mated;
    logic busy;
    logic attach;
    logic start_dock;
    logic start_undock;
    logic cap_wr;
    logic cap_wbit;

    assign ctl_rst_n = rst_plat_n & rst_ctl_n;

    dock_cap_reg u_cap (
        .clk        (clk),
        .rst_plat_n (rst_plat_n),
        .cap_wr     (cap_wr),
        .cap_wbit   (cap_wbit),
        .supported  (supported)
    );

    dock_reg_file #(
        .CTRL_OFS (CTRL_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_regs (
        .clk           (clk),
        .rst_n         (ctl_rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .wr_attach_bit (reg_wdata[ATTACH_BIT]),
        .wr_cap_bit    (reg_wdata[CAP_BIT]),
        .supported     (supported),
        .mated         (mated),
        .busy          (busy),
        .attach        (attach),
        .start_dock    (start_dock),
        .start_undock  (start_undock),
        .cap_wr        (cap_wr),
        .cap_wbit      (cap_wbit),
        .reg_rdata     (reg_rdata)
    );

    dock_seq_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (ctl_rst_n),
        .start_dock   (start_dock),
        .start_undock (start_undock),
        .dock_en_n    (dock_en_n),
        .dock_rst_n   (dock_rst_n),
        .mated        (mated),
        .busy         (busy)
    );

endmodule

// File: rtl/dock_seq_checker.sv
module dock_seq_checker #(
    parameter logic [7:0] CTRL_OFS = 8'h4C
) (
    input logic       clk,
    input logic       ctl_rst_n,
    input logic       rst_plat_n,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic       supported,
    input logic       attach,
    input logic       busy,
    input logic       mated,
    input logic       dock_en_n,
    input logic       dock_rst_n
);

    p_rst_released_only_enabled_r3: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        dock_rst_n |-> !dock_en_n);

    p_mate_after_release_r3: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        $rose(mated) |-> (dock_rst_n && !dock_en_n));

    p_unmate_after_disable_r4: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        $fell(mated) |-> (dock_en_n && !dock_rst_n));

    p_idle_agrees_r6: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        !busy |-> (attach == mated));

    p_locked_out_r5: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        (reg_wr && (reg_addr == CTRL_OFS) && !supported) |=> $stable(attach));

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        (reg_wr && (reg_addr == CTRL_OFS) && busy) |=> $stable(attach));

    p_cap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_plat_n)
        !supported |=> !supported);

endmodule

bind dock_seq_regs dock_seq_checker #(
    .CTRL_OFS (CTRL_OFS)
) u_chk (
    .clk        (clk),
    .ctl_rst_n  (ctl_rst_n),
    .rst_plat_n (rst_plat_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .supported  (supported),
    .attach     (attach),
    .busy       (busy),
    .mated      (mated),
    .dock_en_n  (dock_en_n),
    .dock_rst_n (dock_rst_n)
);

// File: tb/test_dock_seq_regs.sv
`timescale 1ns/1ps
module test_dock_seq_regs;

    localparam int unsigned W    = 5;
    localparam logic [7:0]  CTRL = 8'h4C;
    localparam logic [7:0]  STAT = 8'h4D;

    logic       clk = 1'b0;
    logic       rst_plat_n = 1'b0;
    logic       rst_ctl_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dock_en_n;
    logic       dock_rst_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dock_seq_regs #(.WAIT_CYCLES(W), .CTRL_OFS(CTRL), .STAT_OFS(STAT)) i_dock_seq_regs (
        .clk        (clk),
        .rst_plat_n (rst_plat_n),
        .rst_ctl_n  (rst_ctl_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dock_en_n  (dock_en_n),
        .dock_rst_n (dock_rst_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pins(input string tag, input logic en_n, input logic rs_n);
        check(tag, {6'b0, dock_en_n, dock_rst_n}, {6'b0, en_n, rs_n});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic plat_reset();
        @(negedge clk);
        rst_plat_n = 1'b0;
        #1;
        pins("R9 pins in platform reset", 1'b1, 1'b0);
        @(negedge clk);
        rst_plat_n = 1'b1;
        rst_ctl_n  = 1'b1;
    endtask

    task automatic ctl_reset();
        @(negedge clk);
        rst_ctl_n = 1'b0;
        #1;
        pins("R8 pins in controller reset", 1'b1, 1'b0);
        @(negedge clk);
        rst_ctl_n = 1'b1;
    endtask

    // R3: full docking timeline, one check set per clock
    task automatic dock_track(input logic [7:0] wdata);
        wr(CTRL, wdata);
        pins("R3 enable on write edge", 1'b0, 1'b0);
        rd_check("R3 mated still clear", STAT, 8'h80);
        for (int k = 1; k <= W + 1; k++) begin
            @(negedge clk);
            pins("R3 pin timeline", 1'b0, (k >= W) ? 1'b1 : 1'b0);
            rd_check("R3 mated timeline", STAT, (k >= W + 1) ? 8'h81 : 8'h80);
        end
        rd_check("R3 attach reads 1", CTRL, 8'h01);
    endtask

    // R4: full undocking timeline
    task automatic undock_track();
        wr(CTRL, 8'h00);
        pins("R4 reset on write edge", 1'b0, 1'b0);
        rd_check("R4 mated still set", STAT, 8'h81);
        for (int k = 1; k <= W + 1; k++) begin
            @(negedge clk);
            pins("R4 pin timeline", (k >= W) ? 1'b1 : 1'b0, 1'b0);
            rd_check("R4 mated timeline", STAT, (k >= W + 1) ? 8'h80 : 8'h81);
        end
        rd_check("R4 attach reads 0", CTRL, 8'h00);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_plat_n = 1'b1;
        rst_ctl_n  = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 control reset", CTRL, 8'h00);
        rd_check("R1 status reset", STAT, 8'h80);
        pins("R1 pins out of reset", 1'b1, 1'b0);

        // R2 sweep every offset
        for (int a = 0; a < 256; a++) begin
            logic [7:0] ab = 8'(a);
            rd_check("R2 offset map", ab, (ab == STAT) ? 8'h80 : 8'h00);
        end

        // R3 dock with junk in reserved bits
        dock_track(8'hFF);

        // R6 same-value writes with every reserved pattern
        for (int v = 0; v < 128; v++) begin
            logic [6:0] vb = 7'(v);
            wr(CTRL, {vb, 1'b1});
            pins("R6 repeat write leaves pins", 1'b0, 1'b1);
            rd_check("R2 control reserved bits read 0", CTRL, 8'h01);
        end
        rd_check("R6 mated after repeats", STAT, 8'h81);

        // R4 undock
        undock_track();

        // R6 write during a running sequence
        wr(CTRL, 8'h01);
        @(negedge clk);
        wr(CTRL, 8'h00);
        rd_check("R6 busy write ignored", CTRL, 8'h01);
        pins("R6 busy write keeps enable", 1'b0, 1'b0);
        repeat (W + 2) @(negedge clk);
        pins("R6 sequence still completes", 1'b0, 1'b1);
        rd_check("R6 mated after busy write", STAT, 8'h81);

        // R8 controller reset while docked
        ctl_reset();
        rd_check("R8 attach cleared", CTRL, 8'h00);
        rd_check("R8 mated cleared", STAT, 8'h80);
        pins("R8 pins after reset", 1'b1, 1'b0);

        // R8 controller reset mid-sequence, then a clean dock
        wr(CTRL, 8'h01);
        @(negedge clk);
        ctl_reset();
        rd_check("R8 mid-sequence attach cleared", CTRL, 8'h00);
        repeat (W + 2) @(negedge clk);
        pins("R8 sequencer stopped", 1'b1, 1'b0);
        rd_check("R8 mated stays clear", STAT, 8'h80);
        dock_track(8'h01);
        undock_track();

        // R7 capability cleared and locked, R5 attach locked out
        wr(STAT, 8'h01);
        rd_check("R7 capability from bit 7, mated untouched", STAT, 8'h00);
        wr(STAT, 8'h81);
        rd_check("R7 second write no effect", STAT, 8'h00);
        wr(CTRL, 8'h01);
        rd_check("R5 attach locked", CTRL, 8'h00);
        repeat (W + 2) @(negedge clk);
        pins("R5 no sequence", 1'b1, 1'b0);
        ctl_reset();
        rd_check("R8 capability survives controller reset", STAT, 8'h00);
        wr(STAT, 8'h80);
        rd_check("R8 lock survives controller reset", STAT, 8'h00);

        // R9 platform reset restores the capability
        plat_reset();
        rd_check("R9 status after platform reset", STAT, 8'h80);
        dock_track(8'h01);
        undock_track();

        // R7/R9 exhaustive first-write sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb = 8'(v);
            plat_reset();
            wr(STAT, vb);
            rd_check("R7 first write", STAT, {vb[7], 7'b0});
            wr(STAT, ~vb);
            rd_check("R7 later write ignored", STAT, {vb[7], 7'b0});
            wr(CTRL, 8'h01);
            rd_check("R5 attach gated by capability", CTRL, {7'b0, vb[7]});
            pins("R5 pins follow gate", ~vb[7], 1'b0);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule